// File: doc/BRIEF.md
# Opcode Prefix Sequencer

This block sits at the front of an 8-bit CPU decoder. It takes the opcode byte stream, one byte per fetch strobe, and keeps track of the four prefix bytes CB, ED, DD and FD. For every completed instruction it reports the following, one cycle after the last byte it needs:

- the instruction group;
- the final opcode byte;
- which index register stands in for HL;
- the signed displacement byte, when there is one;
- whether H/L turn into index-register halves;
- the refresh-counter increment.

For indexed-bit forms it also reports the plain register that gets a copy of the result. For the ED group it flags undefined codes and return-form codes.

Index prefixes can be chained. Only the last DD or FD in a run counts. Each earlier one, and a DD or FD that an ED overrides, retires on its own as a one-fetch no-op. The interrupt-blocking output is high whenever an instruction is only partly fetched. The CPU then only accepts interrupts at instruction boundaries. Operand bytes after the displacement, and all execution, belong to later stages.

Top module: `opcode_prefix_seq`

## Requirements
- R1: A synchronous active-high reset returns the sequencer to the idle state. In that state insn_done and int_block are both low.
- R2: In the idle state, a byte other than CB, ED, DD or FD completes at once. insn_done pulses high in the next cycle with grp=0 (plain), and opcode carries that byte.
- R3: In a run of DD/FD bytes, each byte that is followed by another DD/FD retires as grp=5 (stray prefix) with rfsh_inc=1. The last byte of the run sets idx_iy: 0 for DD (IX), 1 for FD (IY).
- R4: An ED that arrives while DD/FD is pending retires that prefix as grp=5. The byte after any ED completes as grp=2 (ED group), even if it is CB, DD, FD or ED. The byte after that starts a fresh instruction.
- R5: CB followed by any byte completes as grp=1 (bit/rotate group), with that byte as opcode.
- R6: DD/FD then CB then d then op completes on op as grp=4 (indexed bit). disp=d, opcode=op and mem_ind=1.
- R7: In grp=4, if op[7:6] is not 01 and op[2:0] is not 110, copy_en=1 and copy_reg=op[2:0] (0..5 = B,C,D,E,H,L; 7 = A). Otherwise copy_en=0.
- R8: A grp=4 opcode in the bit-test group (op[7:6]=01) never sets copy_en, whatever its low three bits.
- R9: ed_nop=1 for an ED-group code outside two ranges: 40h-7Fh other than 77h and 7Fh, and the block codes (op[7:5]=101, op[2]=0). ed_retn=1 for ED codes with op[7:6]=01 and op[2:0]=101.
- R10: rfsh_inc is 1 for grp 0 and grp 5. It is 2 for grp 1, 2, 3 and 4.
- R11: int_block is high from the cycle after any prefix byte is accepted until the cycle in which its instruction completes. It is low in the idle state.
- R12: After DD/FD, an opcode that uses the (HL) memory operand waits for one more byte, the displacement. It then completes as grp=3 with mem_ind=1, half_sub=0 and disp set. Any other opcode completes at once as grp=3 with mem_ind=0, half_sub=1 and disp=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_vld | input | 1 | Byte strobe |
| fetch_byte | input | 8 | Fetched opcode byte |
| insn_done | output | 1 | One-cycle pulse: fields below are valid |
| grp | output | 3 | 0 plain, 1 CB, 2 ED, 3 indexed, 4 indexed bit, 5 stray prefix |
| opcode | output | 8 | Final opcode byte |
| idx_iy | output | 1 | Index select, 0 = IX, 1 = IY |
| disp | output | 8 | Signed displacement |
| mem_ind | output | 1 | Operand is index plus displacement |
| half_sub | output | 1 | H/L mean index register halves |
| copy_en | output | 1 | Indexed-bit result is also written to a register |
| copy_reg | output | 3 | That register |
| ed_nop | output | 1 | ED code is undefined (two no-ops) |
| ed_retn | output | 1 | ED code is a return with interrupt-flag restore |
| rfsh_inc | output | 2 | Refresh counter increment |
| int_block | output | 1 | Instruction partly fetched; hold off interrupts |

## Verification
The bound checker watches several things on every cycle:

- a plain byte fetched in the idle state always completes next cycle with increment 1;
- an index prefix fetched in the idle state always raises the interrupt block without completing;
- a stray retire always comes with increment 1 and a still-pending chain;
- a register copy is only ever reported for indexed-bit, non-memory-only codes, and never for bit tests;
- the ED no-op flag and the half-register flag only appear in their own groups.

Only the bench's byte sequences can show the rest. This covers which prefix of a chain wins and the exact displacement and opcode carried through each multi-byte form. It also covers ED swallowing a following prefix byte and the exact ED decode values.

// File: rtl/opcode_prefix_seq.sv
module opcode_prefix_seq (
  input  logic       clk,
  input  logic       rst,
  input  logic       fetch_vld,
  input  logic [7:0] fetch_byte,
  output logic       insn_done,
  output logic [2:0] grp,
  output logic [7:0] opcode,
  output logic       idx_iy,
  output logic [7:0] disp,
  output logic       mem_ind,
  output logic       half_sub,
  output logic       copy_en,
  output logic [2:0] copy_reg,
  output logic       ed_nop,
  output logic       ed_retn,
  output logic [1:0] rfsh_inc,
  output logic       int_block
);
  localparam logic [2:0] G_PLAIN = 3'd0, G_CB = 3'd1, G_ED = 3'd2,
                         G_IDX = 3'd3, G_IBIT = 3'd4, G_STRAY = 3'd5;

  typedef enum logic [2:0] {S_IDLE, S_CB, S_ED, S_IX, S_IXD, S_BD, S_BOP} st_t;
  st_t st, nst;
  logic       sel_iy, nsel;
  logic [7:0] op_q, nopq, d_q, ndq;

  logic       fin, fmem, fiy;
  logic [2:0] fgrp;
  logic [7:0] fop, fdisp;

  wire b_cb  = fetch_byte == 8'hCB;
  wire b_ed  = fetch_byte == 8'hED;
  wire b_idx = fetch_byte == 8'hDD || fetch_byte == 8'hFD;

  wire hl_mem = (fetch_byte[7:2] == 6'b001101 && fetch_byte[1:0] != 2'b11) ||
                (fetch_byte[7:6] == 2'b01 &&
                 ((fetch_byte[2:0] == 3'b110) ^ (fetch_byte[5:3] == 3'b110))) ||
                (fetch_byte[7:6] == 2'b10 && fetch_byte[2:0] == 3'b110);

  always_comb begin
    nst = st; nsel = sel_iy; nopq = op_q; ndq = d_q;
    fin = 1'b0; fgrp = G_PLAIN; fop = fetch_byte; fiy = 1'b0;
    fdisp = 8'h00; fmem = 1'b0;
    if (fetch_vld) begin
      case (st)
        S_IDLE: begin
          if (b_cb) nst = S_CB;
          else if (b_ed) nst = S_ED;
          else if (b_idx) begin nst = S_IX; nsel = fetch_byte[5]; end
          else fin = 1'b1;
        end
        S_CB: begin fin = 1'b1; fgrp = G_CB; nst = S_IDLE; end
        S_ED: begin fin = 1'b1; fgrp = G_ED; nst = S_IDLE; end
        S_IX: begin
          if (b_idx || b_ed) begin
            fin = 1'b1; fgrp = G_STRAY; fiy = sel_iy;
            fop = sel_iy ? 8'hFD : 8'hDD;
            nsel = fetch_byte[5];
            if (b_ed) nst = S_ED;
          end else if (b_cb) begin
            nst = S_BD;
          end else if (hl_mem) begin
            nopq = fetch_byte; nst = S_IXD;
          end else begin
            fin = 1'b1; fgrp = G_IDX; fiy = sel_iy; nst = S_IDLE;
          end
        end
        S_IXD: begin
          fin = 1'b1; fgrp = G_IDX; fop = op_q; fiy = sel_iy;
          fdisp = fetch_byte; fmem = 1'b1; nst = S_IDLE;
        end
        S_BD: begin ndq = fetch_byte; nst = S_BOP; end
        S_BOP: begin
          fin = 1'b1; fgrp = G_IBIT; fiy = sel_iy;
          fdisp = d_q; fmem = 1'b1; nst = S_IDLE;
        end
        default: nst = S_IDLE;
      endcase
    end
  end

  wire ed_known = (fop[7:6] == 2'b01 && !(fop[5:4] == 2'b11 && fop[2:0] == 3'b111)) ||
                  (fop[7:5] == 3'b101 && !fop[2]);
  wire cp_en    = fgrp == G_IBIT && fop[7:6] != 2'b01 && fop[2:0] != 3'b110;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; sel_iy <= 1'b0; op_q <= 8'h00; d_q <= 8'h00;
      insn_done <= 1'b0; grp <= G_PLAIN; opcode <= 8'h00; idx_iy <= 1'b0;
      disp <= 8'h00; mem_ind <= 1'b0; half_sub <= 1'b0; copy_en <= 1'b0;
      copy_reg <= 3'd0; ed_nop <= 1'b0; ed_retn <= 1'b0; rfsh_inc <= 2'd0;
    end else begin
      st <= nst; sel_iy <= nsel; op_q <= nopq; d_q <= ndq;
      insn_done <= fin;
      if (fin) begin
        grp      <= fgrp;
        opcode   <= fop;
        idx_iy   <= fiy;
        disp     <= fdisp;
        mem_ind  <= fmem;
        half_sub <= fgrp == G_IDX && !fmem;
        copy_en  <= cp_en;
        copy_reg <= cp_en ? fop[2:0] : 3'd0;
        ed_nop   <= fgrp == G_ED && !ed_known;
        ed_retn  <= fgrp == G_ED && fop[7:6] == 2'b01 && fop[2:0] == 3'b101;
        rfsh_inc <= (fgrp == G_PLAIN || fgrp == G_STRAY) ? 2'd1 : 2'd2;
      end
    end
  end

  assign int_block = st != S_IDLE;
endmodule

// File: rtl/opcode_prefix_seq_chk.sv
module opcode_prefix_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       fetch_vld,
  input logic [7:0] fetch_byte,
  input logic       insn_done,
  input logic [2:0] grp,
  input logic [7:0] opcode,
  input logic       mem_ind,
  input logic       half_sub,
  input logic       copy_en,
  input logic [2:0] copy_reg,
  input logic       ed_nop,
  input logic [1:0] rfsh_inc,
  input logic       int_block
);
  wire is_pfx = fetch_byte == 8'hCB || fetch_byte == 8'hED ||
                fetch_byte == 8'hDD || fetch_byte == 8'hFD;

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !insn_done && !int_block);

  assert_plain_next_R2: assert property (@(posedge clk) disable iff (rst)
    fetch_vld && !int_block && !is_pfx |=> insn_done && grp == 3'd0 && rfsh_inc == 2'd1 && !int_block);

  assert_stray_one_R3: assert property (@(posedge clk) disable iff (rst)
    insn_done && grp == 3'd5 |-> rfsh_inc == 2'd1 && int_block);

  assert_copy_dest_R7: assert property (@(posedge clk) disable iff (rst)
    insn_done && copy_en |-> grp == 3'd4 && copy_reg != 3'd6);

  assert_bit_nocopy_R8: assert property (@(posedge clk) disable iff (rst)
    insn_done && grp == 3'd4 && opcode[7:6] == 2'b01 |-> !copy_en);

  assert_ednop_grp_R9: assert property (@(posedge clk) disable iff (rst)
    insn_done && ed_nop |-> grp == 3'd2);

  assert_pfx_block_R11: assert property (@(posedge clk) disable iff (rst)
    fetch_vld && !int_block && (fetch_byte == 8'hDD || fetch_byte == 8'hFD) |=> int_block && !insn_done);

  assert_half_reg_R12: assert property (@(posedge clk) disable iff (rst)
    insn_done && half_sub |-> grp == 3'd3 && !mem_ind);
endmodule

bind opcode_prefix_seq opcode_prefix_seq_chk u_chk (.*);

// File: tb/test_opcode_prefix_seq.sv
`timescale 1ns/1ps
module test_opcode_prefix_seq;
  logic clk = 1'b0, rst = 1'b1, fetch_vld = 1'b0;
  logic [7:0] fetch_byte = 8'h00;
  logic insn_done, idx_iy, mem_ind, half_sub, copy_en, ed_nop, ed_retn, int_block;
  logic [2:0] grp, copy_reg;
  logic [7:0] opcode, disp;
  logic [1:0] rfsh_inc;

  opcode_prefix_seq i_opcode_prefix_seq (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;

  int m_st = 0;
  bit m_iy;
  logic [7:0] m_op, m_d;
  bit e_done, e_iy, e_mem, e_half, e_cp, e_nop, e_ret;
  logic [2:0] e_grp, e_creg;
  logic [7:0] e_op, e_disp;
  logic [1:0] e_rf;

  function automatic bit uses_hl(input logic [7:0] b);
    if (b == 8'h34 || b == 8'h35 || b == 8'h36) return 1;
    if (b >= 8'h40 && b <= 8'h7F && b != 8'h76 && (b[2:0] == 3'd6 || b[5:3] == 3'd6)) return 1;
    if (b >= 8'h80 && b <= 8'hBF && b[2:0] == 3'd6) return 1;
    return 0;
  endfunction

  function automatic bit ed_defined(input logic [7:0] b);
    if (b >= 8'h40 && b <= 8'h7F) return b != 8'h77 && b != 8'h7F;
    if (b >= 8'hA0 && b <= 8'hBB) return b[2] == 1'b0;
    return 0;
  endfunction

  task automatic retire(input logic [2:0] g, input logic [7:0] o, input bit iy,
                        input logic [7:0] d, input bit mem);
    e_done = 1; e_grp = g; e_op = o; e_iy = iy; e_disp = d; e_mem = mem;
    e_half = (g == 3'd3) && !mem;
    e_cp = (g == 3'd4) && (o[7:6] != 2'b01) && (o[2:0] != 3'd6);
    e_creg = e_cp ? o[2:0] : 3'd0;
    e_nop = (g == 3'd2) && !ed_defined(o);
    e_ret = (g == 3'd2) && (o[7:6] == 2'b01) && (o[2:0] == 3'd5);
    e_rf = (g == 3'd0 || g == 3'd5) ? 2'd1 : 2'd2;
  endtask

  task automatic model(input logic [7:0] b);
    bit pf_idx = (b == 8'hDD || b == 8'hFD);
    e_done = 0;
    if (m_st == 0) begin
      if (b == 8'hCB) m_st = 1;
      else if (b == 8'hED) m_st = 2;
      else if (pf_idx) begin m_st = 3; m_iy = (b == 8'hFD); end
      else retire(3'd0, b, 0, 8'h00, 0);
    end else if (m_st == 1) begin retire(3'd1, b, 0, 8'h00, 0); m_st = 0; end
    else if (m_st == 2) begin retire(3'd2, b, 0, 8'h00, 0); m_st = 0; end
    else if (m_st == 3) begin
      if (pf_idx || b == 8'hED) begin
        retire(3'd5, m_iy ? 8'hFD : 8'hDD, m_iy, 8'h00, 0);
        if (pf_idx) m_iy = (b == 8'hFD); else m_st = 2;
      end else if (b == 8'hCB) m_st = 5;
      else if (uses_hl(b)) begin m_op = b; m_st = 4; end
      else begin retire(3'd3, b, m_iy, 8'h00, 0); m_st = 0; end
    end else if (m_st == 4) begin retire(3'd3, m_op, m_iy, b, 1); m_st = 0; end
    else if (m_st == 5) begin m_d = b; m_st = 6; end
    else begin retire(3'd4, b, m_iy, m_d, 1); m_st = 0; end
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic feed(input logic [7:0] b);
    @(negedge clk);
    fetch_vld = 1'b1; fetch_byte = b;
    model(b);
    @(negedge clk);
    fetch_vld = 1'b0;
    check(insn_done == e_done, "R2", "insn_done", insn_done, e_done);
    check(int_block == (m_st != 0), "R11", "int_block", int_block, m_st != 0);
    if (e_done && insn_done) begin
      check(grp == e_grp, "R2", "grp", grp, e_grp);
      check(opcode == e_op, "R6", "opcode", opcode, e_op);
      check(idx_iy == e_iy, "R3", "idx_iy", idx_iy, e_iy);
      check(disp == e_disp, "R6", "disp", disp, e_disp);
      check(mem_ind == e_mem && half_sub == e_half, "R12", "mem/half",
            {mem_ind, half_sub}, {e_mem, e_half});
      check(copy_en == e_cp && copy_reg == e_creg, "R7", "copy",
            {copy_en, copy_reg}, {e_cp, e_creg});
      check(ed_nop == e_nop && ed_retn == e_ret, "R9", "ed flags",
            {ed_nop, ed_retn}, {e_nop, e_ret});
      check(rfsh_inc == e_rf, "R10", "rfsh_inc", rfsh_inc, e_rf);
    end
  endtask

  task automatic gap();
    @(negedge clk);
    fetch_vld = 1'b0;
    @(negedge clk);
    check(!insn_done, "R2", "idle done", insn_done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234ABCD));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!insn_done && !int_block, "R1", "reset state", {insn_done, int_block}, 0);

    // R3: DD DD 21
    feed(8'hDD); feed(8'hDD);
    check(grp == 3'd5 && rfsh_inc == 2'd1, "R3", "stray DD", {grp, rfsh_inc}, {3'd5, 2'd1});
    feed(8'h21);
    check(grp == 3'd3 && !idx_iy && half_sub, "R3", "DD DD 21 as IX", {grp, idx_iy, half_sub}, {3'd3, 1'b0, 1'b1});
    // R3: DD FD 09 -> IY wins
    feed(8'hDD); feed(8'hFD); feed(8'h09);
    check(idx_iy == 1'b1, "R3", "last prefix wins", idx_iy, 1);
    // R4: ED FD 21
    feed(8'hED); feed(8'hFD);
    check(grp == 3'd2 && opcode == 8'hFD && ed_nop, "R4", "ED FD", {grp, opcode, ed_nop}, {3'd2, 8'hFD, 1'b1});
    feed(8'h21);
    check(grp == 3'd0 && rfsh_inc == 2'd1, "R4", "after ED FD", {grp, rfsh_inc}, {3'd0, 2'd1});
    // R4/R9: FD ED 4D
    feed(8'hFD); feed(8'hED);
    check(grp == 3'd5 && idx_iy, "R4", "ED cancels FD", {grp, idx_iy}, {3'd5, 1'b1});
    feed(8'h4D);
    check(ed_retn && !ed_nop, "R9", "ED 4D return", {ed_retn, ed_nop}, 2'b10);
    feed(8'hED); feed(8'h71);
    feed(8'hED); feed(8'h77);
    check(ed_nop, "R9", "ED 77 nop", ed_nop, 1);
    // R5
    feed(8'hCB); feed(8'h37);
    check(grp == 3'd1 && opcode == 8'h37 && rfsh_inc == 2'd2, "R5", "CB 37", {grp, opcode}, {3'd1, 8'h37});
    // R6 R7: DD CB 05 00
    feed(8'hDD); feed(8'hCB); feed(8'h05); feed(8'h00);
    check(grp == 3'd4 && disp == 8'h05 && copy_en && copy_reg == 3'd0, "R6", "DD CB 05 00",
          {grp, disp, copy_en}, {3'd4, 8'h05, 1'b1});
    feed(8'hFD); feed(8'hCB); feed(8'hFE); feed(8'hC7);
    check(copy_en && copy_reg == 3'd7 && disp == 8'hFE, "R7", "copy to A", {copy_en, copy_reg}, {1'b1, 3'd7});
    feed(8'hFD); feed(8'hCB); feed(8'h10); feed(8'h06);
    check(!copy_en, "R7", "memory only", copy_en, 0);
    // R8
    feed(8'hFD); feed(8'hCB); feed(8'h80); feed(8'h7C);
    check(!copy_en && grp == 3'd4, "R8", "BIT no copy", copy_en, 0);
    // R12
    feed(8'hDD); feed(8'h7E);
    check(!insn_done && int_block, "R12", "wait disp", {insn_done, int_block}, 2'b01);
    feed(8'h03);
    check(mem_ind && !half_sub && disp == 8'h03 && opcode == 8'h7E, "R12", "DD 7E 03",
          {mem_ind, half_sub, disp}, {1'b1, 1'b0, 8'h03});
    feed(8'hFD); feed(8'h76);
    check(half_sub && !mem_ind, "R12", "FD 76 not memory", {half_sub, mem_ind}, 2'b10);

    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      logic [7:0] b;
      if (r < 10) b = 8'hDD;
      else if (r < 20) b = 8'hFD;
      else if (r < 27) b = 8'hCB;
      else if (r < 34) b = 8'hED;
      else b = 8'($urandom);
      if ($urandom_range(0, 9) == 0) gap();
      feed(b);
    end

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_st = 0;
    @(negedge clk);
    check(!insn_done && !int_block, "R1", "re-reset", {insn_done, int_block}, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule